// File: doc/BRIEF.md
# Lockable Page Memory Controller

This block guards a small nonvolatile store of sixteen 32-bit pages, held here as a register array. A requester issues single-cycle requests on one port. A read returns four consecutive pages in one 128-bit word. A write offers one page of new data. Each request gets exactly one response, one cycle later. The response says whether the request was granted, and for a read it also carries the data.

The block enforces the store's protection rules on every write. The first two pages, and the low half of page 2, hold the factory identity: a seven-byte serial number, its two check bytes and one internal byte. These bytes can never change. The upper half of page 2 is a 16-bit lock word, and its bits can only be set. Bit p of the lock word makes page p read-only, for p from 3 to 15. The three lowest lock bits are block-lock bits, and each one freezes the lock bits of one page range. Page 3 is a one-time-programmable page: a write to it ORs the new bits into the old ones. Pages 4 to 15 take the write data as given.

After reset the array holds its factory image. The serial-number bytes and the internal byte come from parameters, and the two check bytes are computed from them.

Top module: `lockpage_ctrl`

## Requirements
- R1: A request sampled with `req_valid` high produces `resp_valid` high in the next cycle, and `resp_valid` is low in every other cycle. `resp_rdata` is zero except in the response cycle of a granted read.
- R2: After reset the pages hold the factory image, with byte j of a page in bits [8j+7:8j]. Page 0 is {BCC0, SN2, SN1, SN0} and page 1 is {SN6, SN5, SN4, SN3}. Page 2 is {8'h00, 8'h00, internal byte, BCC1}. The check bytes are BCC0 = 8'h88 ^ SN0 ^ SN1 ^ SN2 and BCC1 = SN3 ^ SN4 ^ SN5 ^ SN6. Page 3 is all zero, page 4 is all ones, and pages 5 to 15 are zero.
- R3: A read at page a (0 to 15) is granted and returns page (a+i) mod 16 in `resp_rdata[32i+31:32i]`, for i = 0 to 3, so a read near the top of the array wraps to page 0.
- R4: A read or write whose `req_addr` is above 15 is denied, returns zero data and leaves every page unchanged.
- R5: Writes to pages 0 and 1 are denied. A write to page 2 is granted, but page 2 bits [15:0] never change.
- R6: A granted page-2 write ORs `req_wdata[31:16]` into the lock word (page 2 bits [31:16]), so lock bits never return to 0. Lock-word bit p locks page p, for p from 3 to 15.
- R7: Lock-word bit 0 freezes lock bit 3, bit 1 freezes lock bits 4 to 9, and bit 2 freezes lock bits 10 to 15. A frozen lock bit keeps its value through any write, and the rest of that write still applies.
- R8: A granted write to page 3 stores the bitwise OR of the old contents and `req_wdata`.
- R9: A write to an unlocked page from 4 to 15 is granted and replaces the page with `req_wdata`.
- R10: A write to a page from 3 to 15 whose lock bit is set is denied, and the page keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the factory image |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Page address of the request |
| req_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| resp_valid | output | 1 | Response present; follows a request by one cycle |
| resp_grant | output | 1 | 1 if the request was carried out, 0 if it was denied |
| resp_rdata | output | 128 | Read data, four pages, the lowest-addressed page in bits [31:0] |

## Verification
The properties assume that the requester keeps `req_valid`, `req_write` and `req_addr` stable over the clock edge where they are sampled. They also assume that reset is asserted from time zero, so that the array starts from its factory image. The bench changes its inputs only on falling edges and holds reset low before the first rising edge, so it stays within both assumptions. Within those limits the stimulus covers every address class: protected pages, the lock page, the one-time page, user pages and out-of-range addresses. It sends both isolated and back-to-back requests, and it sets lock bits both before and after their freeze bits.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int PAGES          = 16;
  localparam int WORD_W         = 32;
  localparam int PG_W           = $clog2(PAGES);
  localparam int LOCK_W         = 16;
  localparam int LOCK_LSB       = WORD_W - LOCK_W;
  localparam int PROT_PAGES     = 2;
  localparam int LOCK_PAGE      = 2;
  localparam int OTP_PAGE       = 3;
  localparam int FIRST_LOCKABLE = 3;
  localparam logic [7:0] CASCADE_TAG = 8'h88;

  typedef logic [WORD_W-1:0] word_t;

  // Which block-lock bit freezes lock bit k (-1 means none).
  function automatic int freeze_src(input int k);
    if (k == 3) return 0;
    if (k >= 4 && k <= 9) return 1;
    if (k >= 10 && k < LOCK_W) return 2;
    return -1;
  endfunction

  function automatic word_t factory_word(input int pg, input logic [55:0] uid,
                                         input logic [7:0] intl);
    logic [7:0] chk0;
    logic [7:0] chk1;
    chk0 = CASCADE_TAG ^ uid[7:0] ^ uid[15:8] ^ uid[23:16];
    chk1 = uid[31:24] ^ uid[39:32] ^ uid[47:40] ^ uid[55:48];
    case (pg)
      0:       return {chk0, uid[23:0]};
      1:       return uid[55:24];
      2:       return {16'h0000, intl, chk1};
      4:       return '1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/lpm_lock_decode.sv
module lpm_lock_decode
  import lpm_pkg::*;
(
  input  logic [LOCK_W-1:0] lock_bits,
  output logic [PAGES-1:0]  page_locked,
  output logic [LOCK_W-1:0] settable
);
  for (genvar k = 0; k < LOCK_W; k++) begin : g_bit
    localparam int SRC = freeze_src(k);
    if (k >= FIRST_LOCKABLE) begin : g_lk
      assign page_locked[k] = lock_bits[k];
    end else begin : g_nolk
      assign page_locked[k] = 1'b0;
    end
    if (SRC < 0) begin : g_free
      assign settable[k] = 1'b1;
    end else begin : g_frz
      assign settable[k] = ~lock_bits[SRC];
    end
  end
endmodule

// File: rtl/lpm_write_merge.sv
module lpm_write_merge
  import lpm_pkg::*;
(
  input  logic [PG_W-1:0]   page,
  input  logic              in_range,
  input  word_t             cur_word,
  input  word_t             wdata,
  input  logic [PAGES-1:0]  page_locked,
  input  logic [LOCK_W-1:0] settable,
  output logic              grant,
  output word_t             new_word
);
  always_comb begin
    grant    = 1'b0;
    new_word = cur_word;
    if (in_range) begin
      if (page < PG_W'(PROT_PAGES)) begin
        grant = 1'b0;
      end else if (page == PG_W'(LOCK_PAGE)) begin
        grant    = 1'b1;
        new_word = {cur_word[WORD_W-1:LOCK_LSB] | (wdata[WORD_W-1:LOCK_LSB] & settable),
                    cur_word[LOCK_LSB-1:0]};
      end else if (page_locked[page]) begin
        grant = 1'b0;
      end else if (page == PG_W'(OTP_PAGE)) begin
        grant    = 1'b1;
        new_word = cur_word | wdata;
      end else begin
        grant    = 1'b1;
        new_word = wdata;
      end
    end
  end
endmodule

// File: rtl/lpm_read_mux.sv
module lpm_read_mux
  import lpm_pkg::*;
#(
  parameter int READ_PAGES = 4
) (
  input  logic [PAGES*WORD_W-1:0]      mem_flat,
  input  logic [PG_W-1:0]              base,
  output logic [READ_PAGES*WORD_W-1:0] rdata
);
  for (genvar i = 0; i < READ_PAGES; i++) begin : g_rd
    logic [PG_W-1:0] idx;
    assign idx = base + PG_W'(i);
    assign rdata[i*WORD_W +: WORD_W] = mem_flat[idx*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/lockpage_ctrl.sv
module lockpage_ctrl
  import lpm_pkg::*;
#(
  parameter logic [55:0] UID           = 56'hF6E5D4C3B2A104,
  parameter logic [7:0]  INTERNAL_BYTE = 8'h48,
  parameter int          ADDR_W        = 8,
  parameter int          READ_PAGES    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [WORD_W-1:0]            req_wdata,
  output logic                         resp_valid,
  output logic                         resp_grant,
  output logic [READ_PAGES*WORD_W-1:0] resp_rdata
);
  localparam int RDATA_W = READ_PAGES * WORD_W;

  word_t                   mem_q [PAGES];
  logic [PAGES*WORD_W-1:0] mem_flat;
  logic [LOCK_W-1:0]       lock_bits;
  logic [PAGES-1:0]        page_locked;
  logic [LOCK_W-1:0]       settable;
  logic                    in_range;
  logic [PG_W-1:0]         page;
  logic                    wr_grant;
  word_t                   wr_word;
  logic [RDATA_W-1:0]      rd_data;
  logic                    wr_en;
  logic                    resp_valid_d;
  logic                    resp_grant_d;
  logic [RDATA_W-1:0]      resp_rdata_d;

  for (genvar p = 0; p < PAGES; p++) begin : g_flat
    assign mem_flat[p*WORD_W +: WORD_W] = mem_q[p];
  end

  assign lock_bits = mem_q[LOCK_PAGE][WORD_W-1:LOCK_LSB];
  assign in_range  = req_addr < ADDR_W'(PAGES);
  assign page      = req_addr[PG_W-1:0];

  lpm_lock_decode u_dec (
    .lock_bits   (lock_bits),
    .page_locked (page_locked),
    .settable    (settable)
  );

  lpm_write_merge u_wr (
    .page        (page),
    .in_range    (in_range),
    .cur_word    (mem_q[page]),
    .wdata       (req_wdata),
    .page_locked (page_locked),
    .settable    (settable),
    .grant       (wr_grant),
    .new_word    (wr_word)
  );

  lpm_read_mux #(.READ_PAGES(READ_PAGES)) u_rd (
    .mem_flat (mem_flat),
    .base     (page),
    .rdata    (rd_data)
  );

  // Next-state logic
  assign wr_en = req_valid & req_write & wr_grant;

  always_comb begin
    resp_valid_d = req_valid;
    resp_grant_d = req_valid & (req_write ? wr_grant : in_range);
    resp_rdata_d = (req_valid & ~req_write & in_range) ? rd_data : '0;
  end

  // Page array with explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) begin
        mem_q[p] <= factory_word(p, UID, INTERNAL_BYTE);
      end
    end else if (wr_en) begin
      mem_q[page] <= wr_word;
    end
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= resp_valid_d;
      resp_grant <= resp_grant_d;
      resp_rdata <= resp_rdata_d;
    end
  end
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker
  import lpm_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int RDATA_W = 128
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_write,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    resp_valid,
  input logic                    resp_grant,
  input logic [RDATA_W-1:0]      resp_rdata,
  input logic [PAGES*WORD_W-1:0] mem_flat
);
  logic [LOCK_W-1:0] lock;
  logic [PG_W-1:0]   pg;
  assign lock = mem_flat[LOCK_PAGE*WORD_W+LOCK_LSB +: LOCK_W];
  assign pg   = req_addr[PG_W-1:0];

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && resp_rdata == '0);
  a_r3_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr < ADDR_W'(PAGES)) |=> resp_grant);
  a_r4_range_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= ADDR_W'(PAGES)) |=>
      (!resp_grant && resp_rdata == '0 && $stable(mem_flat)));
  a_r5_identity_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mem_flat[LOCK_PAGE*WORD_W+LOCK_LSB-1:0]));
  a_r6_locks_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lock) & ~lock) == '0));
  a_r8_otp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mem_flat[OTP_PAGE*WORD_W +: WORD_W]) &
               ~mem_flat[OTP_PAGE*WORD_W +: WORD_W]) == '0));
  a_r10_denied_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_grant) |-> $stable(mem_flat));

  for (genvar p = FIRST_LOCKABLE; p < PAGES; p++) begin : g_pg
    localparam int SRC = freeze_src(p);
    a_r10_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
      lock[p] |=> $stable(mem_flat[p*WORD_W +: WORD_W]));
    a_r10_locked_deny: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr < ADDR_W'(PAGES) &&
       pg == PG_W'(p) && lock[p]) |=> !resp_grant);
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock[SRC] |=> $stable(lock[p]));
  end
endmodule

bind lockpage_ctrl lpm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .resp_valid (resp_valid),
  .resp_grant (resp_grant),
  .resp_rdata (resp_rdata),
  .mem_flat   (mem_flat)
);

// File: tb/lockpage_ctrl_bench.sv
module lockpage_ctrl_bench;
  localparam logic [55:0] UID  = 56'hF6E5D4C3B2A104;
  localparam logic [7:0]  INTB = 8'h48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [7:0]   req_addr = 8'h00;
  logic [31:0]  req_wdata = 32'h0;
  logic         resp_valid;
  logic         resp_grant;
  logic [127:0] resp_rdata;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  lockpage_ctrl u_lockpage_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_grant(resp_grant), .resp_rdata(resp_rdata)
  );

  // Behavioural reference: byte-addressed store
  logic [7:0]   m [64];
  logic         e_valid = 1'b0;
  logic         e_grant = 1'b0;
  logic [127:0] e_rdata = '0;

  task automatic model_init();
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    for (int i = 0; i < 3; i++) m[i] = UID[8*i +: 8];
    m[3] = 8'h88 ^ m[0] ^ m[1] ^ m[2];
    for (int i = 3; i < 7; i++) m[i+1] = UID[8*i +: 8];
    m[8] = m[4] ^ m[5] ^ m[6] ^ m[7];
    m[9] = INTB;
    for (int i = 16; i < 20; i++) m[i] = 8'hFF;
  endtask

  function automatic bit lock_of(input int k);
    logic [15:0] l;
    l = {m[11], m[10]};
    return l[k];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      model_init();
      e_valid = 1'b0; e_grant = 1'b0; e_rdata = '0;
    end else begin
      e_valid = req_valid; e_grant = 1'b0; e_rdata = '0;
      if (req_valid && req_addr < 16) begin
        int pg;
        pg = req_addr;
        if (!req_write) begin
          e_grant = 1'b1;
          for (int i = 0; i < 4; i++)
            for (int b = 0; b < 4; b++)
              e_rdata[32*i + 8*b +: 8] = m[4*((pg + i) % 16) + b];
        end else if (pg == 2) begin
          bit frz [16];
          e_grant = 1'b1;
          for (int k = 0; k < 16; k++)
            frz[k] = (k == 3 && lock_of(0)) || (k >= 4 && k <= 9 && lock_of(1)) ||
                     (k >= 10 && lock_of(2));
          for (int k = 0; k < 16; k++)
            if (req_wdata[16+k] && !frz[k]) m[10 + k/8][k%8] = 1'b1;
        end else if (pg >= 3 && !lock_of(pg)) begin
          e_grant = 1'b1;
          for (int b = 0; b < 4; b++)
            m[4*pg + b] = (pg == 3) ? (m[4*pg + b] | req_wdata[8*b +: 8])
                                    : req_wdata[8*b +: 8];
        end
      end
    end
  end

  // Clock-by-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (resp_valid !== e_valid || resp_grant !== e_grant || resp_rdata !== e_rdata) begin
        failures++;
        $display("FAIL R1/R3 model compare: act v=%b g=%b d=%h exp v=%b g=%b d=%h",
                 resp_valid, resp_grant, resp_rdata, e_valid, e_grant, e_rdata);
      end
    end
  end

  logic         got_grant;
  logic [127:0] got_rdata;

  task automatic op(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    got_grant = resp_grant; got_rdata = resp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: act running exp finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {127'b0, resp_valid}, 128'b0);
    rst_n = 1'b1;

    op(0, 8'd0, 0);
    chk("R2 R3 read page 0 image", got_rdata,
        {32'h00000000, 32'h00004804, 32'hF6E5D4C3, 32'h9FB2A104});
    op(0, 8'd14, 0);
    chk("R3 wrap read", got_rdata, {32'hF6E5D4C3, 32'h9FB2A104, 64'h0});
    op(0, 8'd4, 0);
    chk("R2 page 4 ones", {96'b0, got_rdata[31:0]}, 128'hFFFFFFFF);

    op(1, 8'd0, 32'h0);
    chk("R5 page 0 deny", {127'b0, got_grant}, 128'b0);
    op(1, 8'd1, 32'hFFFFFFFF);
    chk("R5 page 1 deny", {127'b0, got_grant}, 128'b0);
    op(1, 8'd2, 32'h0010ABCD);
    chk("R6 lock write grant", {127'b0, got_grant}, 128'b1);
    op(0, 8'd2, 0);
    chk("R5 R6 page 2 after write", {96'b0, got_rdata[31:0]}, 128'h00104804);

    op(1, 8'd4, 32'h1);
    chk("R10 locked page deny", {127'b0, got_grant}, 128'b0);
    op(0, 8'd4, 0);
    chk("R10 locked page kept", {96'b0, got_rdata[31:0]}, 128'hFFFFFFFF);
    op(1, 8'd5, 32'h12345678);
    op(0, 8'd5, 0);
    chk("R9 replace page 5", {96'b0, got_rdata[31:0]}, 128'h12345678);

    op(1, 8'd3, 32'h0F);
    op(1, 8'd3, 32'hF0);
    op(1, 8'd3, 32'h00);
    op(0, 8'd3, 0);
    chk("R8 otp or", {96'b0, got_rdata[31:0]}, 128'hFF);

    op(1, 8'd16, 32'hFFFFFFFF);
    chk("R4 write addr 16 deny", {127'b0, got_grant}, 128'b0);
    op(1, 8'hFF, 32'hFFFFFFFF);
    chk("R4 write addr 255 deny", {127'b0, got_grant}, 128'b0);
    op(0, 8'd16, 0);
    chk("R4 read addr 16", {got_rdata[127:1], got_grant}, 128'b0);

    op(1, 8'd2, 32'h00020000);
    op(1, 8'd2, 32'h04400000);
    op(0, 8'd2, 0);
    chk("R7 freeze 4-9 only", {96'b0, got_rdata[31:0]}, 128'h04124804);
    op(1, 8'd6, 32'hAA);
    chk("R7 frozen page 6 writable", {127'b0, got_grant}, 128'b1);
    op(1, 8'd10, 32'hAA);
    chk("R10 page 10 locked", {127'b0, got_grant}, 128'b0);

    op(1, 8'd2, 32'h00010000);
    op(1, 8'd2, 32'h00080000);
    op(1, 8'd3, 32'h100);
    chk("R7 otp lock frozen grant", {127'b0, got_grant}, 128'b1);
    op(0, 8'd3, 0);
    chk("R8 otp after freeze", {96'b0, got_rdata[31:0]}, 128'h1FF);

    // Back-to-back mixed traffic, checked by the reference every clock
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      req_valid = (i % 7) != 6;
      req_write = (i % 3) == 0;
      req_addr  = 8'((i * 5) % 19);
      req_wdata = 32'h9E3779B9 * (i + 1);
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule